// File: doc/BRIEF.md
# Serial Shift-and-Add Multiplier

This unit sits in the execute stage of a pipeline and forms the unsigned product of two 32-bit operands. It does this one bit per clock with a shift-and-add loop. An operation begins on the rising edge of the request level, provided decode-valid is high in that same cycle. The unit captures both operands and the half-select at that edge, then runs 32 iterations. At the end it presents the chosen half of the 64-bit product for exactly one cycle.

A pipeline flush cancels a running operation, and so does the request level falling while the unit is busy. In both cases the iteration counter returns to zero and no result is reported. While busy, the unit ignores decode-valid, further request activity and any change on the operand and select inputs.

Top module: `serial_mul_unit`

## Requirements
- R1: While reset is applied and in the first cycle after its release, `busy_o` and `res_valid_o` are low and `res_o` is zero.
- R2: A start occurs when all of the following hold at a clock edge: `op_req_i` is high, it was low at the previous edge, `dec_valid_i` is high, the unit is idle and `flush_i` is low. `busy_o` is high from the next cycle. A request that is already high, or that rises without decode-valid, starts nothing.
- R3: If no abort occurs, `res_valid_o` is high in the 32nd cycle after the start edge. In that cycle `res_o` carries the selected half of the unsigned 64-bit product of the operands captured at the start.
- R4: `hi_sel_i`, captured at the start edge, selects the half of the product: 1 gives bits 63:32 and 0 gives bits 31:0.
- R5: `res_valid_o` is high for exactly one cycle per completed operation. `res_o` is zero whenever `res_valid_o` is low.
- R6: `flush_i` high at an edge while the unit is busy aborts the operation. `busy_o` is low in the next cycle and the aborted operation never raises `res_valid_o`. This holds even when the flush falls on the edge that would have completed it.
- R7: `op_req_i` low at an edge while the unit is busy aborts the operation in the same way as R6, including at the completing edge.
- R8: While busy, changes on `dec_valid_i`, `opa_i`, `opb_i` and `hi_sel_i` neither restart the operation nor alter its result.
- R9: `busy_o` stays high from the cycle after the start until the result cycle or the abort, and is never high together with `res_valid_o`.
- R10: A start attempt in a cycle with `flush_i` high is not accepted.
- R11: No operation stays in flight for more than 33 cycles after its start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req_i | input | 1 | Operation request level; its rising edge starts, its fall aborts |
| dec_valid_i | input | 1 | Decode-valid qualifier for a start |
| flush_i | input | 1 | Pipeline flush; cancels a running operation |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier |
| hi_sel_i | input | 1 | Result half select (1 = high word) |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_o | output | 32 | Selected product half, zero when not valid |
| busy_o | output | 1 | Operation in progress |

## Verification
Completion and cancellation can fall on the same clock edge. This happens when a flush, or a fall of the request level, arrives in the cycle before the 32nd edge. The bench provokes this by placing each kind of abort at the final iteration, and also at the first and at middle iterations. It judges the outcome by checking that `res_valid_o` stays low and `busy_o` drops in the following cycle. A second collision is a start attempt with a flush in the same cycle, which must leave the unit idle.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } smul_state_e;

  typedef struct packed {
    logic start;
    logic abort;
    logic step;
    logic done;
  } smul_evt_t;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_req_i,
  input  logic             dec_valid_i,
  input  logic             flush_i,
  output smul_evt_t        evt_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  smul_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             valid_q;
  logic             running;
  logic             req_rise;
  logic             at_last;

  assign running  = (state_q == SM_RUN);
  assign req_rise = op_req_i & ~req_q;
  assign at_last  = (cnt_q == LAST_ITER);

  always_comb begin
    evt_o       = '0;
    evt_o.start = req_rise & dec_valid_i & ~running & ~flush_i;
    evt_o.abort = running & (flush_i | ~op_req_i);
    evt_o.step  = running & ~evt_o.abort;
    evt_o.done  = evt_o.step & at_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SM_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      req_q   <= op_req_i;
      valid_q <= evt_o.done;
      if (evt_o.start) begin
        state_q <= SM_RUN;
        cnt_q   <= '0;
      end else if (evt_o.abort || evt_o.done) begin
        state_q <= SM_IDLE;
        cnt_q   <= '0;
      end else if (evt_o.step) begin
        cnt_q   <= cnt_q + ONE;
      end
    end
  end

  assign busy_o  = running;
  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opb_i,
  input  logic                hi_sel_i,
  output logic [2*DATA_W-1:0] prod_o,
  output logic                hi_sel_o
);

  localparam int PROD_W = 2 * DATA_W;

  // One iteration: add the multiplicand into the upper half when the
  // current multiplier bit (bit 0) is set, then shift the pair right.
  function automatic logic [PROD_W-1:0] shift_add(
    input logic [PROD_W-1:0] p,
    input logic [DATA_W-1:0] m
  );
    logic [DATA_W:0] sum;
    sum = {1'b0, p[PROD_W-1:DATA_W]} + (p[0] ? {1'b0, m} : '0);
    return {sum, p[DATA_W-1:1]};
  endfunction

  logic [DATA_W-1:0] mcand_q;
  logic [PROD_W-1:0] prod_q;
  logic              hsel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
      hsel_q  <= 1'b0;
    end else if (load_i) begin
      mcand_q <= opa_i;
      prod_q  <= {{DATA_W{1'b0}}, opb_i};
      hsel_q  <= hi_sel_i;
    end else if (step_i) begin
      prod_q  <= shift_add(prod_q, mcand_q);
    end
  end

  assign prod_o   = prod_q;
  assign hi_sel_o = hsel_q;

endmodule

// File: rtl/smul_outsel.sv
module smul_outsel #(
  parameter int DATA_W = 32
) (
  input  logic                valid_i,
  input  logic                hi_sel_i,
  input  logic [2*DATA_W-1:0] prod_i,
  output logic [DATA_W-1:0]   res_o
);

  function automatic logic [DATA_W-1:0] pick_half(
    input logic [2*DATA_W-1:0] p,
    input logic                hi
  );
    return hi ? p[2*DATA_W-1:DATA_W] : p[DATA_W-1:0];
  endfunction

  assign res_o = valid_i ? pick_half(prod_i, hi_sel_i) : '0;

endmodule

// File: rtl/serial_mul_unit.sv
module serial_mul_unit
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_req_i,
  input  logic              dec_valid_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              hi_sel_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              busy_o
);

  smul_evt_t           evt_w;
  logic                start_w;
  logic                abort_w;
  logic                step_w;
  logic                done_w;
  logic [CNT_W-1:0]    cnt_w;
  logic [2*DATA_W-1:0] prod_w;
  logic                hsel_w;

  smul_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_req_i   (op_req_i),
    .dec_valid_i(dec_valid_i),
    .flush_i    (flush_i),
    .evt_o      (evt_w),
    .busy_o     (busy_o),
    .valid_o    (res_valid_o),
    .cnt_o      (cnt_w)
  );

  assign start_w = evt_w.start;
  assign abort_w = evt_w.abort;
  assign step_w  = evt_w.step;
  assign done_w  = evt_w.done;

  smul_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_w),
    .step_i  (step_w),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .hi_sel_i(hi_sel_i),
    .prod_o  (prod_w),
    .hi_sel_o(hsel_w)
  );

  smul_outsel #(.DATA_W(DATA_W)) u_out (
    .valid_i (res_valid_o),
    .hi_sel_i(hsel_w),
    .prod_i  (prod_w),
    .res_o   (res_o)
  );

endmodule

// File: rtl/serial_mul_chk.sv
module serial_mul_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_req_i,
  input logic              flush_i,
  input logic              busy_o,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_o,
  input logic              start_w,
  input logic              abort_w,
  input logic              done_w,
  input logic [CNT_W-1:0]  cnt_w
);

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULLN = CNT_W'(DATA_W);

  // Cycles elapsed since the last start edge, counted while busy.
  logic [CNT_W-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        lat_q <= '0;
    else if (start_w)  lat_q <= '0;
    else if (busy_o)   lat_q <= lat_q + ONE;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (!busy_o && !res_valid_o)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_w |=> busy_o); // R2
  AST_LAT_EXACT: assert property (@(posedge clk) disable iff (!rst_n) res_valid_o |-> (lat_q == FULLN)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid_o |=> !res_valid_o); // R5
  AST_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !res_valid_o |-> (res_o == '0)); // R5
  AST_FLUSH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n) (flush_i && busy_o) |=> (!busy_o && !res_valid_o)); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n) (!op_req_i && busy_o) |=> (!busy_o && !res_valid_o)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !abort_w && !done_w) |=> (busy_o && cnt_w == $past(cnt_w) + ONE)); // R8
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && res_valid_o)); // R9
  AST_FLUSH_NOSTART: assert property (@(posedge clk) disable iff (!rst_n) (flush_i && !busy_o) |=> !busy_o); // R10
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> (lat_q < FULLN + ONE)); // R11

endmodule

bind serial_mul_unit serial_mul_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_req_i   (op_req_i),
  .flush_i    (flush_i),
  .busy_o     (busy_o),
  .res_valid_o(res_valid_o),
  .res_o      (res_o),
  .start_w    (start_w),
  .abort_w    (abort_w),
  .done_w     (done_w),
  .cnt_w      (cnt_w)
);

// File: tb/serial_mul_unit_bench.sv
`timescale 1ns/1ps
module serial_mul_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_req, dec_valid, flush, hi_sel;
  logic [31:0] opa, opb;
  logic        res_valid, busy;
  logic [31:0] res;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_mul_unit u_serial_mul_unit (
    .clk(clk), .rst_n(rst_n), .op_req_i(op_req), .dec_valid_i(dec_valid),
    .flush_i(flush), .opa_i(opa), .opb_i(opb), .hi_sel_i(hi_sel),
    .res_valid_o(res_valid), .res_o(res), .busy_o(busy)
  );

  function automatic logic [31:0] ref_half(input logic [31:0] a, input logic [31:0] b, input logic hs);
    logic [63:0] full;
    full = {32'd0, a} * {32'd0, b};
    return hs ? full[63:32] : full[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_req = 0; dec_valid = 0; flush = 0;
    @(negedge clk);
  endtask

  // abort_k < 0: no abort. Abort is applied at negedge N_abort_k.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic hs,
                        input int abort_k, input bit use_flush, input bit scramble);
    logic [31:0] exp;
    bit aborted;
    exp = ref_half(a, b, hs);
    aborted = 0;
    idle_cycle();
    op_req = 1; dec_valid = 1; opa = a; opb = b; hi_sel = hs;
    @(negedge clk);  // N0
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    dec_valid = 0;
    for (int k = 1; k <= 32; k++) begin
      if (k - 1 == abort_k) begin
        aborted = 1;
        if (use_flush) flush = 1; else op_req = 0;
      end
      if (scramble && !aborted) begin
        opa = $urandom; opb = $urandom; hi_sel = ~hs; dec_valid = 1'($urandom);
      end
      @(negedge clk);
      if (aborted) begin
        flush = 0; dec_valid = 0;
        if (k == abort_k + 1)
          chk(busy === 1'b0, use_flush ? "R6 busy low after flush" : "R7 busy low after req drop", busy, 0);
        chk(res_valid === 1'b0, use_flush ? "R6 no valid after flush" : "R7 no valid after req drop", res_valid, 0);
      end else if (k < 32) begin
        chk(res_valid === 1'b0 && busy === 1'b1, "R9 busy no valid mid-op (R8 scramble)", {busy, res_valid}, 2'b10);
      end else begin
        chk(res_valid === 1'b1 && busy === 1'b0, "R3/R11 valid at cycle 32", {busy, res_valid}, 2'b01);
        chk(res === exp, hs ? "R4 high half (R8)" : "R3 low half (R8)", res, exp);
      end
    end
    if (!aborted) begin
      @(negedge clk);
      chk(res_valid === 1'b0 && res === 32'd0, "R5 one-cycle valid, zero result", {res_valid, res}, 0);
    end
    op_req = 0; dec_valid = 0; flush = 0;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    rst_n = 0; op_req = 0; dec_valid = 0; flush = 0; hi_sel = 0; opa = 0; opb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && res_valid === 1'b0 && res === 32'd0, "R1 idle in reset", {busy, res_valid, res}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && res_valid === 1'b0 && res === 32'd0, "R1 idle after reset", {busy, res_valid, res}, 0);

    // Directed products
    run_op(32'd0, 32'd0, 1'b0, -1, 0, 0);
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, -1, 0, 0);
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, -1, 0, 0);
    run_op(32'h80000000, 32'd2, 1'b1, -1, 0, 0);
    run_op(32'd1, 32'h12345678, 1'b0, -1, 0, 1);
    // Flush and request-drop collisions, including the completing edge
    run_op(32'h1234, 32'h5678, 1'b0, 0, 1, 0);
    run_op(32'h1234, 32'h5678, 1'b0, 15, 1, 1);
    run_op(32'hDEADBEEF, 32'hCAFEF00D, 1'b1, 31, 1, 0);
    run_op(32'hDEADBEEF, 32'hCAFEF00D, 1'b1, 31, 0, 0);
    run_op(32'h0F0F0F0F, 32'h33333333, 1'b0, 5, 0, 1);
    // Recovery after an abort
    run_op(32'h0000FFFF, 32'h0000FFFF, 1'b0, -1, 0, 0);

    // R10: start attempt with flush
    idle_cycle();
    op_req = 1; dec_valid = 1; flush = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R10 start blocked by flush", busy, 0);
    flush = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R2 held-high request does not start", busy, 0);

    // R2: rising edge without decode-valid
    idle_cycle();
    op_req = 1; dec_valid = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R2 rise without decode-valid", busy, 0);
    dec_valid = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R2 decode-valid after rise", busy, 0);

    // Random mix
    for (int i = 0; i < 24; i++) begin
      int r;
      r = int'($urandom % 4);
      run_op($urandom, $urandom, 1'($urandom), (r == 0) ? int'($urandom % 32) : -1,
             1'($urandom), 1'($urandom));
    end

    idle_cycle();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule